// File: doc/BRIEF.md
# Precision DAC register interface

This block is the digital front end of a precision voltage-output DAC. It works as an SPI slave. It receives 24-bit command words and keeps four registers: the DAC input code, a control word, a clear code and a self-clearing software-control word. It presents the resulting output code and the analog configuration bits as plain outputs for the conversion stage. It also handles three asynchronous pins: load, clear and reset.

A write goes into the input register first. The output code changes only on a load event, which is a falling edge on the load pin or the software load bit. A clear event copies the clear code into the output instead. A read takes two frames. The read command is followed by a second frame, normally a no-op, and during that second frame the addressed register is shifted out. All pins are resynchronised into the system clock, so the SPI clock must be several times slower than `clk`.

Top module: `prec_dac_regif`

## Requirements
- R1: A frame is 24 SCLK cycles while `cs_n` is low. MOSI is taken MSB first on each SCLK falling edge (SPI mode 1). Bit 23 = 0 marks a write, bits 22:20 hold the address and bits 19:0 hold the data. The write takes effect when `cs_n` rises. Address 1 loads the input register, address 2 the control word and address 3 the clear code.
- R2: A frame of any length other than 24 clocks changes no register.
- R3: A write to address 1 leaves `dac_code` unchanged. The input register moves to `dac_code` on a falling edge of `ldac_n`, or on a write to address 4 with data bit 0 set.
- R4: A falling edge of `clr_n`, or a write to address 4 with data bit 1 set, loads the clear code into `dac_code`. If bits 0 and 1 are set in the same word, the clear wins.
- R5: The control word drives the outputs as follows: bit 1 drives `ref_buf_sel`, bit 2 `clamp_gnd`, bit 3 `out_hiz`, bit 4 `offset_bin` and bits 9:6 `lin_comp`. `out_live` is high only when bits 2 and 3 are both clear. Bit 0 always reads back as 0.
- R6: After a frame with bit 23 = 1, the next frame shifts out {1, address, register value} MSB first on `sdo`. The value is taken when `cs_n` falls and advances after each SCLK falling edge. `sdo_oe` is high during that frame only. Addresses 0, 4, 5, 6 and 7 return a value of 0.
- R7: While control bit 5 is set, `sdo_oe` stays low during the read-back frame.
- R8: A write to address 4 with data bit 2 set clears the input register, the clear code and `dac_code`, and sets the control word to 0x00C (clamp and tri-state set).
- R9: `reset_pin_n` held low for at least RST_MIN clock cycles gives the same reset as R8. A shorter low pulse has no effect.
- R10: While `rst_n` is low, every register takes the reset state of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data in |
| sdo | output | 1 | SPI read-back data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| ldac_n | input | 1 | Load pin, acts on its falling edge |
| clr_n | input | 1 | Clear pin, acts on its falling edge |
| reset_pin_n | input | 1 | Qualified hardware reset pin, active low |
| dac_code | output | 20 | Output register value |
| ref_buf_sel | output | 1 | Reference buffer gain select |
| clamp_gnd | output | 1 | Clamp output to ground through a resistor |
| out_hiz | output | 1 | Tri-state the output |
| offset_bin | output | 1 | Offset-binary coding select |
| lin_comp | output | 4 | Linearity-compensation code |
| out_live | output | 1 | Output is driven (neither clamped nor tri-stated) |

## Verification
A corrupt control word appears on the configuration outputs within a few cycles of `cs_n` rising. A wrong input register or clear code stays hidden until the next load or clear event copies it into `dac_code`, so the bench always follows such writes with a load or a read-back. A bad shift or snapshot in the read path shows up only in the second frame of a read, one bit per SCLK period. Frame-length, priority and reset-qualification faults are exposed by directed frames and pulses whose effect, or lack of effect, is checked on the pins directly.

// File: rtl/prec_dac_regif.sv
module prec_dac_regif #(
  parameter int DATA_W  = 20,
  parameter int ADDR_W  = 3,
  parameter int LINC_W  = 4,
  parameter int RST_MIN = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              reset_pin_n,
  output logic [DATA_W-1:0] dac_code,
  output logic              ref_buf_sel,
  output logic              clamp_gnd,
  output logic              out_hiz,
  output logic              offset_bin,
  output logic [LINC_W-1:0] lin_comp,
  output logic              out_live
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int RC_W    = $clog2(RST_MIN + 1);
  localparam int CTRL_W  = 6 + LINC_W;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(12);
  localparam logic [ADDR_W-1:0] A_DAC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SW  = ADDR_W'(4);
  localparam logic [5:0] PIN_IDLE = 6'b010111;

  // pin order: sclk, cs_n, mosi, ldac_n, clr_n, reset_pin_n
  logic [5:0] pin_m, pin_s;
  logic [3:0] pin_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_m <= PIN_IDLE;
      pin_s <= PIN_IDLE;
      pin_p <= 4'b0111;
    end else begin
      pin_m <= {sclk, cs_n, mosi, ldac_n, clr_n, reset_pin_n};
      pin_s <= pin_m;
      pin_p <= {pin_s[5], pin_s[4], pin_s[2], pin_s[1]};
    end

  wire sclk_fall = pin_p[3] & ~pin_s[5];
  wire cs_fall   = pin_p[2] & ~pin_s[4];
  wire cs_rise   = ~pin_p[2] & pin_s[4];
  wire cs_low    = ~pin_s[4];
  wire ldac_fall = pin_p[1] & ~pin_s[2];
  wire clr_fall  = pin_p[0] & ~pin_s[1];

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               rd_pend, rd_act;
  logic [ADDR_W-1:0]  rd_addr;
  logic [DATA_W-1:0]  din_q, clrc_q, rd_word;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [RC_W-1:0]    rst_cnt;

  wire                frame_ok = cs_rise && (bit_cnt == CNT_W'(FRAME_W));
  wire [ADDR_W-1:0]   rx_addr  = rx_q[FRAME_W-2 -: ADDR_W];
  wire [DATA_W-1:0]   rx_data  = rx_q[DATA_W-1:0];
  wire                wr       = frame_ok && !rx_q[FRAME_W-1];

  wire sw_word = wr && (rx_addr == A_SW);
  wire hw_rst  = (rst_cnt == RC_W'(RST_MIN));
  wire do_rst  = (sw_word && rx_data[2]) || hw_rst;
  wire do_clr  = (sw_word && rx_data[1]) || clr_fall;
  wire do_ldac = (sw_word && rx_data[0]) || ldac_fall;

  always_comb
    case (rd_addr)
      A_DAC:   rd_word = din_q;
      A_CTL:   rd_word = DATA_W'(ctrl_q);
      A_CLR:   rd_word = clrc_q;
      default: rd_word = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rd_pend <= 1'b0;
      rd_act  <= 1'b0;
      rd_addr <= '0;
    end else begin
      if (cs_fall) bit_cnt <= '0;
      else if (cs_low && sclk_fall) begin
        rx_q <= {rx_q[FRAME_W-2:0], pin_s[3]};
        if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_fall) begin
        tx_q    <= {1'b1, rd_addr, rd_word};
        rd_act  <= rd_pend;
        rd_pend <= 1'b0;
      end else if (cs_low && sclk_fall) begin
        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        rd_act <= 1'b0;
        if (frame_ok && rx_q[FRAME_W-1]) begin
          rd_pend <= 1'b1;
          rd_addr <= rx_addr;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_cnt <= '0;
    else if (pin_s[0]) rst_cnt <= '0;
    else if (!hw_rst) rst_cnt <= rst_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      din_q    <= '0;
      clrc_q   <= '0;
      ctrl_q   <= CTRL_RST;
      dac_code <= '0;
    end else if (do_rst) begin
      din_q    <= '0;
      clrc_q   <= '0;
      ctrl_q   <= CTRL_RST;
      dac_code <= '0;
    end else begin
      if (wr && rx_addr == A_DAC) din_q  <= rx_data;
      if (wr && rx_addr == A_CLR) clrc_q <= rx_data;
      if (wr && rx_addr == A_CTL) ctrl_q <= {rx_data[CTRL_W-1:1], 1'b0};
      if (do_clr) dac_code <= clrc_q;
      else if (do_ldac) dac_code <= din_q;
    end

  assign sdo         = tx_q[FRAME_W-1];
  assign sdo_oe      = rd_act && cs_low && !ctrl_q[5];
  assign ref_buf_sel = ctrl_q[1];
  assign clamp_gnd   = ctrl_q[2];
  assign out_hiz     = ctrl_q[3];
  assign offset_bin  = ctrl_q[4];
  assign lin_comp    = ctrl_q[CTRL_W-1 -: LINC_W];
  assign out_live    = !ctrl_q[2] && !ctrl_q[3];

  p_bad_len_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CNT_W'(FRAME_W) && !hw_rst)
      |=> ($stable(din_q) && $stable(ctrl_q) && $stable(clrc_q)));

  p_input_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rx_addr == A_DAC && !do_clr && !do_ldac && !do_rst) |=> $stable(dac_code));

  p_code_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> $past(do_clr || do_ldac || do_rst));

  p_sdo_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && cs_low && !sclk_fall && !cs_fall) |=> $stable(sdo));

  p_pin_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (ctrl_q == CTRL_RST && dac_code == '0 && clrc_q == '0));
endmodule

// File: tb/prec_dac_regif_tb_top.sv
`timescale 1ns/1ps
module prec_dac_regif_tb_top;
  localparam int RST_MIN = 2500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic ldac_n = 1'b1, clr_n = 1'b1, reset_pin_n = 1'b1;
  logic sdo, sdo_oe, ref_buf_sel, clamp_gnd, out_hiz, offset_bin, out_live;
  logic [19:0] dac_code;
  logic [3:0]  lin_comp;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  prec_dac_regif #(.RST_MIN(RST_MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ldac_n(ldac_n), .clr_n(clr_n),
    .reset_pin_n(reset_pin_n), .dac_code(dac_code), .ref_buf_sel(ref_buf_sel),
    .clamp_gnd(clamp_gnd), .out_hiz(out_hiz), .offset_bin(offset_bin),
    .lin_comp(lin_comp), .out_live(out_live));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits,
                      output logic [23:0] rx, output logic oe_seen);
    rx = '0; oe_seen = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b1; mosi = tx[i];
      repeat (4) @(negedge clk);
      rx = {rx[22:0], sdo};
      if (sdo_oe) oe_seen = 1'b1;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    logic [23:0] rx; logic oe;
    xfer({8'h00, 1'b0, a, d}, 24, rx, oe);
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] word, output logic oe);
    logic [23:0] rx0; logic oe0;
    xfer({8'h00, 1'b1, a, 20'h0}, 24, rx0, oe0);
    xfer(32'h0, 24, word, oe);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ldac_n = 1'b0; else clr_n = 1'b0;
    repeat (6) @(negedge clk);
    ldac_n = 1'b1; clr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R10 dac_code", dac_code, 0);
    chk("R10 clamp/hiz", {clamp_gnd, out_hiz}, 2'b11);
    chk("R10 out_live", out_live, 0);
    chk("R10 offset/ref/lin", {offset_bin, ref_buf_sel, lin_comp}, 0);
    chk("R10 sdo_oe", sdo_oe, 0);
  endtask

  task automatic t_ldac_pin;
    wr(3'd1, 20'h12345);
    chk("R3 held before load", dac_code, 0);
    pulse(0);
    chk("R3 pin load", dac_code, 20'h12345);
  endtask

  task automatic t_sw_ldac;
    wr(3'd1, 20'hABCDE);
    chk("R1 write to input only", dac_code, 20'h12345);
    wr(3'd4, 20'h00001);
    chk("R3 soft load", dac_code, 20'hABCDE);
  endtask

  task automatic t_ctrl;
    wr(3'd2, 20'h00313);
    chk("R5 ref_buf_sel", ref_buf_sel, 1);
    chk("R5 offset_bin", offset_bin, 1);
    chk("R5 lin_comp", lin_comp, 4'd12);
    chk("R5 clamp/hiz clear", {clamp_gnd, out_hiz}, 0);
    chk("R5 out_live", out_live, 1);
  endtask

  task automatic t_clear;
    wr(3'd3, 20'h00F0F);
    wr(3'd1, 20'h55555);
    wr(3'd4, 20'h00003);
    chk("R4 clear beats load", dac_code, 20'h00F0F);
    wr(3'd1, 20'h11111);
    wr(3'd4, 20'h00001);
    chk("R4 setup load", dac_code, 20'h11111);
    pulse(1);
    chk("R4 pin clear", dac_code, 20'h00F0F);
  endtask

  task automatic t_readback;
    logic [23:0] w; logic oe;
    rd(3'd2, w, oe);
    chk("R6 read ctrl word", w, {1'b1, 3'd2, 20'h00312});
    chk("R6 oe during readback", oe, 1);
    rd(3'd3, w, oe);
    chk("R6 read clear code", w, {1'b1, 3'd3, 20'h00F0F});
    rd(3'd1, w, oe);
    chk("R6 read input reg", w, {1'b1, 3'd1, 20'h11111});
    rd(3'd4, w, oe);
    chk("R6 sw ctrl reads zero", w, {1'b1, 3'd4, 20'h0});
    xfer(32'h0, 24, w, oe);
    chk("R6 oe off on plain frame", oe, 0);
  endtask

  task automatic t_bad_len;
    logic [23:0] w; logic oe;
    xfer(32'h003AAAAA, 23, w, oe);
    xfer(32'h003AAAAA, 25, w, oe);
    rd(3'd3, w, oe);
    chk("R2 odd frames ignored", w, {1'b1, 3'd3, 20'h00F0F});
  endtask

  task automatic t_sdo_off;
    logic [23:0] w; logic oe;
    wr(3'd2, 20'h00332);
    rd(3'd2, w, oe);
    chk("R7 oe stays low", oe, 0);
    wr(3'd2, 20'h00312);
    rd(3'd2, w, oe);
    chk("R7 oe back after clear", oe, 1);
  endtask

  task automatic t_sw_reset;
    logic [23:0] w; logic oe;
    wr(3'd4, 20'h00004);
    chk("R8 dac cleared", dac_code, 0);
    chk("R8 clamp/hiz set", {clamp_gnd, out_hiz, out_live}, 3'b110);
    rd(3'd3, w, oe);
    chk("R8 clear code zero", w, {1'b1, 3'd3, 20'h0});
    wr(3'd4, 20'h00001);
    chk("R8 input reg zero", dac_code, 0);
  endtask

  task automatic t_pin_reset;
    logic [23:0] w; logic oe;
    wr(3'd2, 20'h00312);
    wr(3'd1, 20'h22222);
    wr(3'd4, 20'h00001);
    @(negedge clk); reset_pin_n = 1'b0;
    repeat (100) @(negedge clk); reset_pin_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 short pulse ignored code", dac_code, 20'h22222);
    chk("R9 short pulse ignored ctrl", out_live, 1);
    reset_pin_n = 1'b0;
    repeat (RST_MIN + 50) @(negedge clk); reset_pin_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 long pulse code", dac_code, 0);
    chk("R9 long pulse clamp/hiz", {clamp_gnd, out_hiz}, 2'b11);
    rd(3'd2, w, oe);
    chk("R9 ctrl reset value", w, {1'b1, 3'd2, 20'h0000C});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state;
    t_ldac_pin;
    t_sw_ldac;
    t_ctrl;
    t_clear;
    t_readback;
    t_bad_len;
    t_sdo_off;
    t_sw_reset;
    t_pin_reset;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule